// File: doc/BRIEF.md
# Bus interjection detector

This block watches a sampled copy of a serial bus's clock and data lines and spots an interjection. The bus uses this in-band event both to reset itself and to mark the end of a message. An interjection is a burst of data-line pulses sent while the bus clock stays high. The block counts rising data edges that arrive during a clock-high phase. When the count reaches a threshold of at least three, it raises a one-cycle strobe. Data activity while the clock is low, or across a clock low phase, never adds up to an interjection.

After the strobe, the block follows the bus clock through the control phase. The first bus-clock rising edge marks the start of control. The second and third rising edges are the sample points of the two control bits, and the data level at each is reported. A fresh interjection that arrives while control is still running restarts this count and flags the event as nested. While the node reports itself idle, the detector is held cleared.

The bus lines must already be synchronised to the system clock `clk`, which oversamples them.

Top module: `intj_detector`

## Requirements
- R1: With the node not idle, the detector counts each rising edge of the data line seen while the bus clock was high on both the previous and the current sample. When the count reaches `PULSES_N` (default 3), `intj_stb_o` pulses high for one cycle.
- R2: A data rising edge seen while the bus clock is low, or in the same sample in which the bus clock rises, does not advance the count.
- R3: A falling bus-clock edge clears the count, so pulses in separate clock-high phases never add up. Two pulses per phase over several phases give no strobe.
- R4: Pulses beyond `PULSES_N` in the same clock-high phase produce no further strobe.
- R5: After an interjection, the outputs follow the bus-clock rising edges in order:
  - 1st rising edge: `begin_stb_o`.
  - 2nd rising edge: `cb0_stb_o`.
  - 3rd rising edge: `cb1_stb_o`.
  - At each control-bit strobe, `cbit_o` takes the data level of that sample and holds it afterwards.
  - `busy_o` is high from the interjection until the `cb1_stb_o` edge, then low.
  - At most one of the four strobes is high in any cycle.
- R6: While `node_idle_i` is high, the count stays clear and no strobe is raised. Any control phase in progress is abandoned, and `busy_o` and `nested_o` drop to 0.
- R7: `nested_o` reports whether the most recent interjection arrived while `busy_o` was high:
  - An interjection while `busy_o` is high sets `nested_o` to 1 and restarts the control sequence at the wait for the first rising edge.
  - An interjection while `busy_o` is low sets `nested_o` to 0.
- R8: After synchronous reset, every output is 0.
- R9: Every output is registered and responds two `clk` cycles after the input sample that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Synchronised bus clock line |
| bus_dat_i | input | 1 | Synchronised bus data line |
| node_idle_i | input | 1 | High while the node is idle; holds the detector cleared |
| intj_stb_o | output | 1 | One-cycle strobe when an interjection is recognised |
| begin_stb_o | output | 1 | Strobe at the start of the control phase |
| cb0_stb_o | output | 1 | Strobe at the first control-bit sample |
| cb1_stb_o | output | 1 | Strobe at the second control-bit sample |
| cbit_o | output | 1 | Data level captured at the latest control-bit strobe |
| nested_o | output | 1 | Latest interjection arrived during a control phase |
| busy_o | output | 1 | Control phase in progress |

## Verification
The hardest case to reach from the ports is a nested interjection. The stimulus first completes an interjection and one bus-clock rise, which puts the block inside control. It then holds the clock high and sends a fresh three-pulse burst before the control bits arrive. A second corner is a data rise that lands in the same sample as the clock rise. The bench drives both lines together from low to high and shows that exactly one more pulse is then needed to fire. A behavioural model that keeps only a count and a phase number is compared against every output on every cycle.

// File: rtl/intj_pkg.sv
package intj_pkg;

  // positions of the lines inside the sampler vector
  localparam int LN_CLK  = 0;
  localparam int LN_DAT  = 1;
  localparam int LN_IDLE = 2;
  localparam int LN_NUM  = 3;

  typedef enum logic [1:0] {
    SQ_IDLE       = 2'd0,
    SQ_WAIT_BEGIN = 2'd1,
    SQ_WAIT_B0    = 2'd2,
    SQ_WAIT_B1    = 2'd3
  } seq_state_t;

endpackage

// File: rtl/intj_line_sampler.sv
module intj_line_sampler
  import intj_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bus_clk_i,
  input  logic bus_dat_i,
  input  logic node_idle_i,
  output logic clk_high_o,
  output logic clk_rise_o,
  output logic clk_fall_o,
  output logic dat_rise_o,
  output logic dat_now_o,
  output logic idle_o
);

  logic [LN_NUM-1:0] raw;
  logic [LN_NUM-1:0] cur;
  logic [LN_NUM-1:0] prv;

  assign raw[LN_CLK]  = bus_clk_i;
  assign raw[LN_DAT]  = bus_dat_i;
  assign raw[LN_IDLE] = node_idle_i;

  // two sample stages per line; reset value matches an idle bus (all high)
  genvar g;
  for (g = 0; g < LN_NUM; g++) begin : g_line
    logic c_q;
    logic p_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        c_q <= 1'b1;
        p_q <= 1'b1;
      end else begin
        c_q <= raw[g];
        p_q <= c_q;
      end
    end
    assign cur[g] = c_q;
    assign prv[g] = p_q;
  end

  assign clk_high_o = cur[LN_CLK] & prv[LN_CLK];
  assign clk_rise_o = cur[LN_CLK] & ~prv[LN_CLK];
  assign clk_fall_o = ~cur[LN_CLK] & prv[LN_CLK];
  assign dat_rise_o = cur[LN_DAT] & ~prv[LN_DAT];
  assign dat_now_o  = cur[LN_DAT];
  assign idle_o     = cur[LN_IDLE];

endmodule

// File: rtl/intj_pulse_counter.sv
module intj_pulse_counter #(
  parameter int PULSES_N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_high_i,
  input  logic clk_fall_i,
  input  logic dat_rise_i,
  input  logic idle_i,
  output logic fire_o
);

  localparam int CW = $clog2(PULSES_N + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(PULSES_N - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(PULSES_N);

  logic [CW-1:0] cnt_q;
  logic          bump;

  assign bump   = clk_high_i & dat_rise_i;
  assign fire_o = ~idle_i & bump & (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || idle_i) begin
      cnt_q <= '0;
    end else if (clk_fall_i) begin
      cnt_q <= '0;
    end else if (bump && (cnt_q != CNT_FULL)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // clock not high: the count may never grow
  assert_low_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    !clk_high_i |=> (cnt_q <= $past(cnt_q)));

  // the firing pulse lands the count on its saturation value
  assert_fire_full_R1: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> (cnt_q == CNT_FULL));

  // a falling clock always empties the count
  assert_fall_clears_R3: assert property (@(posedge clk) disable iff (rst)
    clk_fall_i |=> (cnt_q == '0));

endmodule

// File: rtl/intj_ctrl_seq.sv
module intj_ctrl_seq
  import intj_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic clk_rise_i,
  input  logic dat_now_i,
  input  logic idle_i,
  output logic intj_stb_o,
  output logic begin_stb_o,
  output logic cb0_stb_o,
  output logic cb1_stb_o,
  output logic cbit_o,
  output logic nested_o,
  output logic busy_o
);

  seq_state_t state_q;
  logic intj_q, begin_q, cb0_q, cb1_q, cbit_q, nested_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      intj_q   <= 1'b0;
      begin_q  <= 1'b0;
      cb0_q    <= 1'b0;
      cb1_q    <= 1'b0;
      cbit_q   <= 1'b0;
      nested_q <= 1'b0;
    end else begin
      intj_q  <= 1'b0;
      begin_q <= 1'b0;
      cb0_q   <= 1'b0;
      cb1_q   <= 1'b0;
      if (idle_i) begin
        state_q  <= SQ_IDLE;
        nested_q <= 1'b0;
      end else if (fire_i) begin
        nested_q <= (state_q != SQ_IDLE);
        state_q  <= SQ_WAIT_BEGIN;
        intj_q   <= 1'b1;
      end else if (clk_rise_i) begin
        case (state_q)
          SQ_WAIT_BEGIN: begin
            state_q <= SQ_WAIT_B0;
            begin_q <= 1'b1;
          end
          SQ_WAIT_B0: begin
            state_q <= SQ_WAIT_B1;
            cb0_q   <= 1'b1;
            cbit_q  <= dat_now_i;
          end
          SQ_WAIT_B1: begin
            state_q <= SQ_IDLE;
            cb1_q   <= 1'b1;
            cbit_q  <= dat_now_i;
          end
          default: ;
        endcase
      end
    end
  end

  assign intj_stb_o  = intj_q;
  assign begin_stb_o = begin_q;
  assign cb0_stb_o   = cb0_q;
  assign cb1_stb_o   = cb1_q;
  assign cbit_o      = cbit_q;
  assign nested_o    = nested_q;
  assign busy_o      = (state_q != SQ_IDLE);

  assert_idle_clears_R6: assert property (@(posedge clk) disable iff (rst)
    idle_i |=> (state_q == SQ_IDLE && !nested_q && !intj_q));

  assert_nested_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (fire_i && !idle_i && state_q != SQ_IDLE) |=>
      (nested_q && intj_q && state_q == SQ_WAIT_BEGIN));

  assert_cb0_then_b1_R5: assert property (@(posedge clk) disable iff (rst)
    cb0_q |-> (state_q == SQ_WAIT_B1));

  assert_cb1_leaves_R5: assert property (@(posedge clk) disable iff (rst)
    cb1_q |-> (state_q == SQ_IDLE));

endmodule

// File: rtl/intj_detector.sv
module intj_detector #(
  parameter int PULSES_N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_clk_i,
  input  logic bus_dat_i,
  input  logic node_idle_i,
  output logic intj_stb_o,
  output logic begin_stb_o,
  output logic cb0_stb_o,
  output logic cb1_stb_o,
  output logic cbit_o,
  output logic nested_o,
  output logic busy_o
);

  logic clk_high, clk_rise, clk_fall, dat_rise, dat_now, idle_s;
  logic fire;

  intj_line_sampler u_smp (
    .clk         (clk),
    .rst         (rst),
    .bus_clk_i   (bus_clk_i),
    .bus_dat_i   (bus_dat_i),
    .node_idle_i (node_idle_i),
    .clk_high_o  (clk_high),
    .clk_rise_o  (clk_rise),
    .clk_fall_o  (clk_fall),
    .dat_rise_o  (dat_rise),
    .dat_now_o   (dat_now),
    .idle_o      (idle_s)
  );

  intj_pulse_counter #(.PULSES_N(PULSES_N)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .clk_high_i (clk_high),
    .clk_fall_i (clk_fall),
    .dat_rise_i (dat_rise),
    .idle_i     (idle_s),
    .fire_o     (fire)
  );

  intj_ctrl_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .fire_i      (fire),
    .clk_rise_i  (clk_rise),
    .dat_now_i   (dat_now),
    .idle_i      (idle_s),
    .intj_stb_o  (intj_stb_o),
    .begin_stb_o (begin_stb_o),
    .cb0_stb_o   (cb0_stb_o),
    .cb1_stb_o   (cb1_stb_o),
    .cbit_o      (cbit_o),
    .nested_o    (nested_o),
    .busy_o      (busy_o)
  );

  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({intj_stb_o, begin_stb_o, cb0_stb_o, cb1_stb_o}));

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> !(intj_stb_o || begin_stb_o || cb0_stb_o || cb1_stb_o || busy_o || nested_o));

endmodule

// File: tb/sim_intj_detector.sv
`timescale 1ns/1ps
module sim_intj_detector;

  localparam int N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bc = 1'b1, bd = 1'b1, idl = 1'b1;
  logic intj, beg, c0, c1, cbit, nest, busy;

  always #4 clk = ~clk;

  intj_detector #(.PULSES_N(N)) u0 (
    .clk(clk), .rst(rst), .bus_clk_i(bc), .bus_dat_i(bd), .node_idle_i(idl),
    .intj_stb_o(intj), .begin_stb_o(beg), .cb0_stb_o(c0), .cb1_stb_o(c1),
    .cbit_o(cbit), .nested_o(nest), .busy_o(busy)
  );

  int total = 0, bad = 0;
  bit chk_en = 0;
  bit done = 0;

  // ---------------- behavioural reference model ----------------
  int m_cnt = 0, m_phase = 0;
  bit m_pc = 1, m_pd = 1;
  logic [6:0] mo = '0, expv = '0;
  bit o_i, o_b, o_0, o_1, o_cb, o_n;

  always @(posedge clk) begin
    bit hi, rise, fall, dr, fire;
    expv = mo;
    if (rst) begin
      m_cnt = 0; m_phase = 0; m_pc = 1; m_pd = 1;
      o_cb = 0; o_n = 0;
      mo = '0;
    end else begin
      hi = bc && m_pc; rise = bc && !m_pc; fall = !bc && m_pc; dr = bd && !m_pd;
      o_i = 0; o_b = 0; o_0 = 0; o_1 = 0;
      fire = !idl && hi && dr && (m_cnt == N - 1);
      if (idl) begin
        m_phase = 0; o_n = 0; m_cnt = 0;
      end else begin
        if (fire) begin
          o_n = (m_phase != 0); m_phase = 1; o_i = 1;
        end else if (rise && m_phase != 0) begin
          if (m_phase == 1) o_b = 1;
          else if (m_phase == 2) begin o_0 = 1; o_cb = bd; end
          else begin o_1 = 1; o_cb = bd; end
          m_phase = (m_phase == 3) ? 0 : m_phase + 1;
        end
        if (fall) m_cnt = 0;
        else if (hi && dr && m_cnt < N) m_cnt++;
      end
      mo = {o_i, o_b, o_0, o_1, o_cb, o_n, (m_phase != 0)};
      m_pc = bc; m_pd = bd;
    end
  end

  // R9: every output compared with the model one sample after the model step
  int n_intj = 0, n_beg = 0, n_c0 = 0, n_c1 = 0;
  bit v_c0 = 0, v_c1 = 0;
  always @(negedge clk) begin
    if (chk_en && !done) begin
      total++;
      if ({intj, beg, c0, c1, cbit, nest, busy} !== expv) begin
        bad++;
        $display("FAIL R9 cycle compare: actual=%b expected=%b",
                 {intj, beg, c0, c1, cbit, nest, busy}, expv);
      end
    end
    if (intj) n_intj++;
    if (beg)  n_beg++;
    if (c0) begin n_c0++; v_c0 = cbit; end
    if (c1) begin n_c1++; v_c1 = cbit; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic d, input int n);
    bc = c; bd = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic hpulse();
    drive(1'b1, 1'b0, 2); drive(1'b1, 1'b1, 2);
  endtask

  task automatic lpulse();
    drive(1'b0, 1'b0, 2); drive(1'b0, 1'b1, 2);
  endtask

  task automatic bclk(input logic d);
    drive(1'b0, d, 3); drive(1'b1, d, 3);
  endtask

  task automatic clear();
    drive(1'b0, 1'b1, 3); drive(1'b1, 1'b1, 3);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: outputs at reset
    chk("R8 reset outputs", int'({intj, beg, c0, c1, cbit, nest, busy}), 0);
    rst = 1'b0; idl = 1'b0;
    chk_en = 1;
    drive(1'b1, 1'b1, 4);
    chk("R8 after release", int'({intj, beg, c0, c1, cbit, nest, busy}), 0);

    // R1 + R5: basic interjection and control bits 1 then 0
    n_intj = 0; n_beg = 0; n_c0 = 0; n_c1 = 0;
    for (int i = 0; i < 3; i++) hpulse();
    drive(1'b1, 1'b1, 4);
    chk("R1 three pulses fire once", n_intj, 1);
    chk("R5 busy after interjection", int'(busy), 1);
    bclk(1'b1);
    chk("R5 begin strobe", n_beg, 1);
    chk("R5 no bit yet", n_c0, 0);
    bclk(1'b1);
    bclk(1'b0);
    drive(1'b1, 1'b1, 3);
    chk("R5 bit0 strobe", n_c0, 1);
    chk("R5 bit0 value", int'(v_c0), 1);
    chk("R5 bit1 strobe", n_c1, 1);
    chk("R5 bit1 value", int'(v_c1), 0);
    chk("R5 busy released", int'(busy), 0);

    // R2: toggles while clock low ignored
    clear(); n_intj = 0;
    drive(1'b0, 1'b1, 2);
    for (int i = 0; i < 5; i++) lpulse();
    drive(1'b1, 1'b1, 4);
    chk("R2 low-clock toggles", n_intj, 0);
    // R2: data rising together with the clock rise is not counted
    drive(1'b0, 1'b0, 3);
    drive(1'b1, 1'b1, 2);
    hpulse(); hpulse();
    drive(1'b1, 1'b1, 3);
    chk("R2 coincident rise not counted", n_intj, 0);
    hpulse();
    drive(1'b1, 1'b1, 3);
    chk("R2 third true pulse fires", n_intj, 1);
    bclk(1'b1); bclk(1'b1); bclk(1'b1);

    // R3: pulses split over phases never add up
    clear(); n_intj = 0;
    for (int p = 0; p < 3; p++) begin
      hpulse(); hpulse();
      drive(1'b0, 1'b1, 3); drive(1'b1, 1'b1, 3);
    end
    chk("R3 split phases", n_intj, 0);

    // R4: long burst fires once; R7 nested from within control
    clear(); n_intj = 0; n_beg = 0; n_c1 = 0;
    for (int i = 0; i < 6; i++) hpulse();
    drive(1'b1, 1'b1, 3);
    chk("R4 six pulses single strobe", n_intj, 1);
    chk("R7 fresh not nested", int'(nest), 0);
    bclk(1'b1);
    chk("R7 begin before nesting", n_beg, 1);
    for (int i = 0; i < 3; i++) hpulse();
    drive(1'b1, 1'b1, 3);
    chk("R7 nested strobe", n_intj, 2);
    chk("R7 nested flag", int'(nest), 1);
    bclk(1'b1);
    chk("R7 control restarted", n_beg, 2);
    bclk(1'b0); bclk(1'b1);
    drive(1'b1, 1'b1, 3);
    chk("R7 nested control completes", n_c1, 1);
    chk("R7 flag kept after control", int'(nest), 1);
    clear();
    for (int i = 0; i < 3; i++) hpulse();
    drive(1'b1, 1'b1, 3);
    chk("R7 fresh clears flag", int'(nest), 0);
    bclk(1'b1); bclk(1'b1); bclk(1'b1);

    // R6: idle node ignores everything and abandons control
    clear(); n_intj = 0; n_c0 = 0;
    idl = 1'b1;
    for (int i = 0; i < 3; i++) hpulse();
    drive(1'b1, 1'b1, 3);
    chk("R6 idle no strobe", n_intj, 0);
    chk("R6 idle not busy", int'(busy), 0);
    idl = 1'b0;
    clear();
    for (int i = 0; i < 3; i++) hpulse();
    drive(1'b1, 1'b1, 3);
    bclk(1'b1);
    idl = 1'b1;
    drive(1'b1, 1'b1, 4);
    chk("R6 idle drops busy", int'(busy), 0);
    idl = 1'b0;
    bclk(1'b1); bclk(1'b1);
    drive(1'b1, 1'b1, 3);
    chk("R6 abandoned control gives no bit", n_c0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule